// File: doc/BRIEF.md
# Masked Periodic Alarm Comparator

This block keeps four alarm bytes (seconds, minutes, hours and day of month) that software loads through a byte-wide write port. It compares them with a running BCD time of day that comes from outside the block. Bit 7 of each alarm byte is a repeat mask. Together the four mask bits choose how often the alarm recurs: once a month, once a day, once an hour, once a minute or once a second.

The time-of-day source also supplies a one-second tick. On each rising edge of the tick, the block compares the alarm fields that the current repeat rate requires. If they all match and the single enable input is high, it drives a one-cycle pulse on the interrupt output.

A write is checked before it is stored. The value field must be valid BCD and must lie within the legal range for its field. A write that fails either check is dropped, and the alarm byte keeps its previous contents. Writes use a valid/ready handshake. Ready is held high, so the block never back-pressures, and a beat counts only in a cycle where valid is high. Reads are combinational from a separate select input.

Top module: `alarm_comparator`

## Requirements
- R1: After reset the seconds, minutes and hours bytes read 8'h00, the date byte reads 8'h01, and irq is low.
- R2: Field select encoding is 0 = seconds, 1 = minutes, 2 = hours, 3 = date. An accepted write stores all 8 bits, including bit 7 (the mask), and a read returns that byte exactly. wr_ready is always high, and no byte changes in a cycle without wr_valid.
- R3: For seconds and minutes, bits 6:0 are two BCD digits. A write is accepted only if both digits are valid decimal digits and the value is between 0 and 59. Any other write is discarded.
- R4: For hours, bits 5:0 are BCD. A write is accepted only if both digits are valid and the value is between 0 and 23. Any other write is discarded.
- R5: For date, bits 5:0 are BCD. A write is accepted only if both digits are valid and the value is not zero. Any other write is discarded.
- R6: With all four mask bits clear, a tick fires only when the date, hour, minute and second all match the time-of-day inputs.
- R7: With only the date mask set, a tick compares hour, minute and second. With the date and hour masks set, it compares minute and second. With the date, hour and minute masks set, it compares the second only.
- R8: Any other mask combination makes every tick fire.
- R9: irq rises in the cycle after the clock edge that samples a rising edge of tick. It stays high for exactly one cycle. A tick held high produces only one pulse.
- R10: While irq_en is low at the sampling edge, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Always high; write is taken when valid |
| wr_sel | input | 2 | Alarm field written (0 sec, 1 min, 2 hour, 3 date) |
| wr_data | input | 8 | Mask bit 7 plus BCD value |
| rd_sel | input | 2 | Alarm field read back |
| rd_data | output | 8 | Stored alarm byte selected by rd_sel |
| tod_sec | input | 7 | Current seconds, BCD |
| tod_min | input | 7 | Current minutes, BCD |
| tod_hour | input | 6 | Current hours, BCD |
| tod_date | input | 6 | Current day of month, BCD |
| tick | input | 1 | One-second strobe; rising edge triggers a comparison |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | One-cycle alarm pulse |

## Verification
The hardest condition to reach from the ports is a specific mask combination paired with a mismatch in exactly one field that the active rate does or does not ignore. Such a pairing needs a full reload of all four alarm bytes before the tick. The bench therefore crosses all 16 mask patterns with all 16 patterns of which fields differ from the time of day. Before each tick it rewrites the bytes and predicts the pulse from the decoded repeat rate. Every field also receives all 256 byte values, with readback after each write, so that every accept and reject boundary is exercised.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int NUM_FIELDS = 4;
  localparam int BYTE_W     = 8;
  localparam int SEL_W      = $clog2(NUM_FIELDS);
  localparam int VAL_W      = 7;

  typedef enum logic [SEL_W-1:0] {
    FLD_SEC  = 2'd0,
    FLD_MIN  = 2'd1,
    FLD_HOUR = 2'd2,
    FLD_DATE = 2'd3
  } field_e;

  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MINUTE,
    RPT_SECOND
  } rpt_e;

  // Width of the BCD value inside each alarm byte
  function automatic int field_width(input int idx);
    return (idx < 2) ? 7 : 6;
  endfunction

  function automatic int field_lo(input int idx);
    return (idx == 3) ? 1 : 0;
  endfunction

  function automatic int field_hi(input int idx);
    case (idx)
      0, 1:    return 59;
      2:       return 23;
      default: return 39;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] field_rst(input int idx);
    return (idx == 3) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/alarm_field_reg.sv
module alarm_field_reg
  import alarm_cmp_pkg::*;
#(
  parameter int                VBITS = 7,
  parameter int                LO    = 0,
  parameter int                HI    = 59,
  parameter logic [BYTE_W-1:0] RST   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] q
);
  localparam logic [VAL_W-1:0] VMASK = VAL_W'((1 << VBITS) - 1);

  logic [VAL_W-1:0] val;
  logic [3:0]       units;
  logic [2:0]       tens;
  int unsigned      dec;
  logic             legal;

  always_comb begin
    val   = wr_data[VAL_W-1:0] & VMASK;
    units = val[3:0];
    tens  = val[6:4];
    dec   = 32'(tens) * 10 + 32'(units);
    legal = (units <= 4'd9) && (dec >= LO) && (dec <= HI);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= RST;
    else if (wr_en && legal)
      q <= wr_data;
  end
endmodule

// File: rtl/alarm_rpt_decode.sv
module alarm_rpt_decode
  import alarm_cmp_pkg::*;
(
  input  logic [NUM_FIELDS-1:0] mask,
  output logic [NUM_FIELDS-1:0] need
);
  rpt_e mode;

  always_comb begin
    case (mask)
      4'b0000: mode = RPT_MONTH;
      4'b1000: mode = RPT_DAY;
      4'b1100: mode = RPT_HOUR;
      4'b1110: mode = RPT_MINUTE;
      default: mode = RPT_SECOND;
    endcase
  end

  always_comb begin
    case (mode)
      RPT_MONTH:  need = 4'b1111;
      RPT_DAY:    need = 4'b0111;
      RPT_HOUR:   need = 4'b0011;
      RPT_MINUTE: need = 4'b0001;
      default:    need = 4'b0000;
    endcase
  end
endmodule

// File: rtl/alarm_fire.sv
module alarm_fire
  import alarm_cmp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  irq_en,
  input  logic [NUM_FIELDS-1:0] need,
  input  logic [NUM_FIELDS-1:0] eq,
  output logic                  irq
);
  logic tick_q;
  logic rise;
  logic hit;

  assign rise = tick & ~tick_q;
  assign hit  = &(eq | ~need);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      tick_q <= tick;
      irq    <= rise & irq_en & hit;
    end
  end
endmodule

// File: rtl/alarm_comparator.sv
module alarm_comparator
  import alarm_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [6:0]        tod_sec,
  input  logic [6:0]        tod_min,
  input  logic [5:0]        tod_hour,
  input  logic [5:0]        tod_date,
  input  logic              tick,
  input  logic              irq_en,
  output logic              irq
);
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] field_q;
  logic [NUM_FIELDS-1:0][VAL_W-1:0]  tod_v;
  logic [NUM_FIELDS-1:0]             mask;
  logic [NUM_FIELDS-1:0]             eq;
  logic [NUM_FIELDS-1:0]             need;

  assign wr_ready = 1'b1;
  assign tod_v[0] = tod_sec;
  assign tod_v[1] = tod_min;
  assign tod_v[2] = {1'b0, tod_hour};
  assign tod_v[3] = {1'b0, tod_date};

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam int               W     = field_width(i);
    localparam logic [VAL_W-1:0] CMASK = VAL_W'((1 << W) - 1);

    alarm_field_reg #(
      .VBITS(W),
      .LO   (field_lo(i)),
      .HI   (field_hi(i)),
      .RST  (field_rst(i))
    ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_valid && (wr_sel == SEL_W'(i))),
      .wr_data(wr_data),
      .q      (field_q[i])
    );

    assign mask[i] = field_q[i][BYTE_W-1];
    assign eq[i]   = ((field_q[i][VAL_W-1:0] ^ tod_v[i]) & CMASK) == '0;
  end

  assign rd_data = field_q[rd_sel];

  alarm_rpt_decode u_dec (
    .mask(mask),
    .need(need)
  );

  alarm_fire u_fire (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .irq_en(irq_en),
    .need  (need),
    .eq    (eq),
    .irq   (irq)
  );
endmodule

// File: rtl/alarm_comparator_chk.sv
module alarm_comparator_chk
  import alarm_cmp_pkg::*;
(
  input logic                             clk,
  input logic                             rst_n,
  input logic                             wr_valid,
  input logic                             wr_ready,
  input logic                             tick,
  input logic                             irq_en,
  input logic                             irq,
  input logic [NUM_FIELDS-1:0][BYTE_W-1:0] field_q
);
  logic [3:0] m;
  assign m = {field_q[3][7], field_q[2][7], field_q[1][7], field_q[0][7]};

  assert_irq_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_from_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick));

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en));

  assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(field_q));

  assert_ready_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);

  assert_every_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !$past(tick) && irq_en &&
     m != 4'b0000 && m != 4'b1000 && m != 4'b1100 && m != 4'b1110) |=> irq);
endmodule

bind alarm_comparator alarm_comparator_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_valid(wr_valid),
  .wr_ready(wr_ready),
  .tick    (tick),
  .irq_en  (irq_en),
  .irq     (irq),
  .field_q (field_q)
);

// File: tb/alarm_comparator_bench.sv
`timescale 1ns/1ps
module alarm_comparator_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic [6:0] tod_sec = '0;
  logic [6:0] tod_min = '0;
  logic [5:0] tod_hour = '0;
  logic [5:0] tod_date = '0;
  logic       tick = 1'b0;
  logic       irq_en = 1'b0;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] shadow [4];

  always #4 clk = ~clk;

  alarm_comparator u_alarm_comparator (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .tod_sec(tod_sec), .tod_min(tod_min), .tod_hour(tod_hour), .tod_date(tod_date),
    .tick(tick), .irq_en(irq_en), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic bit accept(input int f, input logic [7:0] v);
    int w, u, t, d;
    w = (f < 2) ? 7 : 6;
    u = int'(v[3:0]);
    t = (w == 7) ? int'(v[6:4]) : int'(v[5:4]);
    d = t * 10 + u;
    if (u > 9) return 0;
    case (f)
      0, 1:    return d <= 59;
      2:       return d <= 23;
      default: return d != 0;
    endcase
  endfunction

  task automatic write_field(input int f, input logic [7:0] v);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_sel   = 2'(f);
    wr_data  = v;
    @(negedge clk);
    wr_valid = 1'b0;
    wr_data  = 8'hA5;
    if (accept(f, v)) shadow[f] = v;
  endtask

  task automatic readback(input string req, input int f);
    rd_sel = 2'(f);
    #1;
    check(req, rd_data, shadow[f]);
  endtask

  task automatic pulse_tick(input string req, input bit exp_fire, input int hold);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    check(req, {7'b0, irq}, {7'b0, exp_fire});
    for (int k = 1; k < hold; k++) begin
      @(negedge clk);
      check("R9 held tick", {7'b0, irq}, 8'h00);
    end
    tick = 1'b0;
    @(negedge clk);
    check("R9 pulse end", {7'b0, irq}, 8'h00);
  endtask

  function automatic logic [3:0] need_of(input logic [3:0] m);
    case (m)
      4'b0000: return 4'b1111;
      4'b1000: return 4'b0111;
      4'b1100: return 4'b0011;
      4'b1110: return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    shadow[0] = 8'h00; shadow[1] = 8'h00; shadow[2] = 8'h00; shadow[3] = 8'h01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    for (int f = 0; f < 4; f++) readback("R1 reset value", f);
    check("R1 irq low", {7'b0, irq}, 8'h00);
    check("R2 ready high", {7'b0, wr_ready}, 8'h01);

    // R3 R4 R5 sweep every byte into every field
    for (int f = 0; f < 4; f++) begin
      for (int v = 0; v < 256; v++) begin
        write_field(f, 8'(v));
        case (f)
          0, 1:    readback("R3 sec/min write", f);
          2:       readback("R4 hour write", f);
          default: readback("R5 date write", f);
        endcase
      end
      for (int o = 0; o < 4; o++) readback("R2 other fields untouched", o);
    end

    // R6 R7 R8: every mask pattern crossed with every mismatch pattern
    irq_en = 1'b1;
    for (int m = 0; m < 16; m++) begin
      write_field(0, {m[0], 7'h56});
      write_field(1, {m[1], 7'h34});
      write_field(2, {m[2], 7'h12});
      write_field(3, {m[3], 7'h15});
      for (int f = 0; f < 4; f++) readback("R2 mask bit stored", f);
      for (int d = 0; d < 16; d++) begin
        logic [3:0] nd;
        nd = need_of(4'(m));
        tod_sec  = d[0] ? 7'h57 : 7'h56;
        tod_min  = d[1] ? 7'h35 : 7'h34;
        tod_hour = d[2] ? 6'h13 : 6'h12;
        tod_date = d[3] ? 6'h16 : 6'h15;
        if (m == 0)
          pulse_tick("R6 monthly match", (nd & 4'(d)) == 0, 1);
        else if (nd != 0)
          pulse_tick("R7 masked rate match", (nd & 4'(d)) == 0, 1);
        else
          pulse_tick("R8 every second", 1'b1, 1);
      end
    end

    // R9 held tick gives one pulse
    tod_sec = 7'h00;
    pulse_tick("R9 long tick first pulse", 1'b1, 4);

    // R10 enable low suppresses
    irq_en = 1'b0;
    pulse_tick("R10 disabled", 1'b0, 1);
    irq_en = 1'b1;
    write_field(0, 8'h56); write_field(1, 8'h34);
    write_field(2, 8'h12); write_field(3, 8'h15);
    tod_sec = 7'h56; tod_min = 7'h34; tod_hour = 6'h12; tod_date = 6'h15;
    irq_en = 1'b0;
    pulse_tick("R10 disabled on full match", 1'b0, 1);
    irq_en = 1'b1;
    pulse_tick("R6 re-enabled full match", 1'b1, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule